// File: doc/BRIEF.md
# Time-Ordered Event Priority Queue

This block keeps a small set of pending signal-change events for a hardware event-driven logic simulator. Each event carries an unsigned timestamp in units of 0.1 ns, the identifier of the signal that changes, and the new one-bit value. The host adds events through a valid/ready port and takes the earliest one with a pop request. The answer comes back one cycle later on a registered output. Empty, full and a sticky overflow flag show the queue's state.

Storage is a register array kept sorted at all times. An add shifts the later entries up by one slot. A remove shifts every entry down by one slot. An add and a remove can complete in the same cycle. Events that carry the same timestamp leave in the order they arrived, so the queue works as the event wheel of a simulator.

Top module: `evq_top`

## Requirements
- R1: After a synchronous reset, `empty` is 1 and `full` is 0. `overflow` and `pop_valid` are 0, and `in_ready` is 1.
- R2: A pop request on a non-empty queue raises `pop_valid` on the next cycle. The outputs `pop_time`, `pop_sig` and `pop_val` then show the stored event with the smallest timestamp, and that event is removed from the queue.
- R3: Events that share a timestamp are removed in the order in which they were accepted.
- R4: `empty` is 1 exactly when the queue holds no events. It is updated in the cycle after the operation that changes the event count.
- R5: `full` is 1 exactly when the queue holds DEPTH events. While `full` is 1, `in_ready` is 0 and an add is not accepted, even if a pop is requested in the same cycle.
- R6: An add attempted while `in_ready` is 0 sets `overflow` on the next cycle. `overflow` stays at 1 until reset.
- R7: A pop request on an empty queue leaves `pop_valid` at 0 on the next cycle and does not change the stored events.
- R8: When an add is accepted and a pop is requested in the same cycle, the pop returns the earliest event from before the add, even if the new event is earlier. The new event stays in the queue.
- R9: Timestamps are compared as unsigned integers over their full width. Time 0 is the earliest value and the all-ones value is the latest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An add is offered |
| in_ready | output | 1 | An add can be accepted (queue not full) |
| in_time | input | TIME_W | Timestamp of the offered event, in 0.1 ns units |
| in_sig | input | SIG_W | Identifier of the signal that changes |
| in_val | input | 1 | New value of the signal |
| pop_req | input | 1 | Request to remove the earliest event |
| pop_valid | output | 1 | The pop outputs hold a removed event |
| pop_time | output | TIME_W | Timestamp of the removed event |
| pop_sig | output | SIG_W | Signal identifier of the removed event |
| pop_val | output | 1 | Value of the removed event |
| empty | output | 1 | No events are stored |
| full | output | 1 | DEPTH events are stored |
| overflow | output | 1 | Sticky flag: an add was refused |

## Verification
The assertions check the handshake and flag rules on every cycle. A full queue holds `in_ready` low, a refused add raises `overflow`, which then stays set, and a pop answers valid or invalid according to `empty`. Empty and full hold their values when no operation can change them. The order of the events that leave the queue cannot be seen in one cycle. Earliest-first removal, first-in order among equal timestamps, and the rule that a combined add and pop returns the old head are shown only by the bench's scenarios, which compare every pop with a sorted reference model.

// File: rtl/evq_pkg.sv
package evq_pkg;
  // Operation applied to the sorted array in a cycle
  typedef enum logic [1:0] {
    OP_HOLD = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_BOTH = 2'b11
  } evq_op_e;
endpackage

// File: rtl/evq_locate.sv
// Marks each stored slot whose time is not later than the new time.
// Because the array is sorted, the mark vector is a thermometer.
module evq_locate #(
  parameter int DEPTH  = 16,
  parameter int TIME_W = 16
) (
  input  logic [DEPTH-1:0][TIME_W-1:0] slot_time,
  input  logic [DEPTH-1:0]             slot_vld,
  input  logic [TIME_W-1:0]            new_time,
  output logic [DEPTH:0]               not_later
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign not_later[i] = slot_vld[i] && (slot_time[i] <= new_time);
  end
  assign not_later[DEPTH] = 1'b0;
endmodule

// File: rtl/evq_cell.sv
// Next-state selection for one slot of the sorted array.
module evq_cell
  import evq_pkg::*;
#(
  parameter int EW       = 21,
  parameter bit IS_FIRST = 1'b0
) (
  input  evq_op_e       op,
  input  logic [EW-1:0] cur,
  input  logic [EW-1:0] prv,
  input  logic [EW-1:0] nxt,
  input  logic [EW-1:0] ins,
  input  logic          le_prev,
  input  logic          le_self,
  input  logic          le_next,
  output logic [EW-1:0] d
);
  always_comb begin
    d = cur;
    unique case (op)
      OP_PUSH: begin
        if (le_self)                 d = cur;
        else if (IS_FIRST || le_prev) d = ins;
        else                         d = prv;
      end
      OP_POP: d = nxt;
      OP_BOTH: begin
        if (le_next)                 d = nxt;
        else if (IS_FIRST || le_self) d = ins;
        else                         d = cur;
      end
      default: d = cur;
    endcase
  end
endmodule

// File: rtl/evq_top.sv
module evq_top
  import evq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int TIME_W = 16,
  parameter int SIG_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [TIME_W-1:0] in_time,
  input  logic [SIG_W-1:0]  in_sig,
  input  logic              in_val,
  input  logic              pop_req,
  output logic              pop_valid,
  output logic [TIME_W-1:0] pop_time,
  output logic [SIG_W-1:0]  pop_sig,
  output logic              pop_val,
  output logic              empty,
  output logic              full,
  output logic              overflow
);
  localparam int EW  = TIME_W + SIG_W + 1;
  localparam int CW  = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

  logic [DEPTH-1:0][EW-1:0]     slot_q;
  logic [DEPTH-1:0][EW-1:0]     slot_d;
  logic [DEPTH-1:0][TIME_W-1:0] slot_time;
  logic [DEPTH-1:0]             slot_vld;
  logic [DEPTH:0]               not_later;
  logic [CW-1:0]                count_q, count_d;
  logic                         empty_q, full_q, ovf_q;
  logic                         do_push, do_pop;
  logic [EW-1:0]                ins_evt;
  evq_op_e                      op;

  assign in_ready = !full_q;
  assign do_push  = in_valid && !full_q;
  assign do_pop   = pop_req && !empty_q;
  assign op       = evq_op_e'({do_pop, do_push});
  assign ins_evt  = {in_time, in_sig, in_val};

  for (genvar i = 0; i < DEPTH; i++) begin : g_view
    assign slot_time[i] = slot_q[i][EW-1 -: TIME_W];
    assign slot_vld[i]  = (CW'(i) < count_q);
  end

  evq_locate #(.DEPTH(DEPTH), .TIME_W(TIME_W)) u_locate (
    .slot_time (slot_time),
    .slot_vld  (slot_vld),
    .new_time  (in_time),
    .not_later (not_later)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [EW-1:0] prv_w, nxt_w;
    logic          le_prev_w;
    if (i == 0) begin : g_head
      assign prv_w     = ins_evt;
      assign le_prev_w = 1'b1;
    end else begin : g_body
      assign prv_w     = slot_q[i-1];
      assign le_prev_w = not_later[i-1];
    end
    if (i == DEPTH - 1) begin : g_tail
      assign nxt_w = slot_q[i];
    end else begin : g_mid
      assign nxt_w = slot_q[i+1];
    end
    evq_cell #(.EW(EW), .IS_FIRST(i == 0)) u_cell (
      .op      (op),
      .cur     (slot_q[i]),
      .prv     (prv_w),
      .nxt     (nxt_w),
      .ins     (ins_evt),
      .le_prev (le_prev_w),
      .le_self (not_later[i]),
      .le_next (not_later[i+1]),
      .d       (slot_d[i])
    );
  end

  always_comb begin
    count_d = count_q;
    if (do_push && !do_pop)      count_d = count_q + 1'b1;
    else if (do_pop && !do_push) count_d = count_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q    <= '0;
      count_q   <= '0;
      empty_q   <= 1'b1;
      full_q    <= 1'b0;
      ovf_q     <= 1'b0;
      pop_valid <= 1'b0;
      pop_time  <= '0;
      pop_sig   <= '0;
      pop_val   <= 1'b0;
    end else begin
      slot_q    <= slot_d;
      count_q   <= count_d;
      empty_q   <= (count_d == '0);
      full_q    <= (count_d == CNT_MAX);
      if (in_valid && full_q) ovf_q <= 1'b1;
      pop_valid <= do_pop;
      if (do_pop) begin
        pop_time <= slot_q[0][EW-1 -: TIME_W];
        pop_sig  <= slot_q[0][SIG_W:1];
        pop_val  <= slot_q[0][0];
      end
    end
  end

  assign empty    = empty_q;
  assign full     = full_q;
  assign overflow = ovf_q;
endmodule

// File: rtl/evq_chk.sv
module evq_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic pop_req,
  input logic pop_valid,
  input logic empty,
  input logic full,
  input logic overflow
);
  a_r5_full_blocks: assert property (@(posedge clk) disable iff (rst)
    full |-> !in_ready);
  a_r4_empty_not_full: assert property (@(posedge clk) disable iff (rst)
    empty |-> !full);
  a_r6_ovf_set: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |=> overflow);
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  a_r7_pop_empty: assert property (@(posedge clk) disable iff (rst)
    (pop_req && empty) |=> !pop_valid);
  a_r2_pop_answer: assert property (@(posedge clk) disable iff (rst)
    (pop_req && !empty) |=> pop_valid);
  a_r4_idle_empty: assert property (@(posedge clk) disable iff (rst)
    (empty && !in_valid) |=> empty);
  a_r5_full_hold: assert property (@(posedge clk) disable iff (rst)
    (full && !pop_req) |=> full);
endmodule

bind evq_top evq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .pop_req   (pop_req),
  .pop_valid (pop_valid),
  .empty     (empty),
  .full      (full),
  .overflow  (overflow)
);

// File: tb/tb_evq_top.sv
module tb_evq_top;
  localparam int DEPTH  = 16;
  localparam int TIME_W = 16;
  localparam int SIG_W  = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [TIME_W-1:0] in_time = '0;
  logic [SIG_W-1:0]  in_sig = '0;
  logic              in_val = 1'b0;
  logic              pop_req = 1'b0;
  logic              pop_valid;
  logic [TIME_W-1:0] pop_time;
  logic [SIG_W-1:0]  pop_sig;
  logic              pop_val;
  logic              empty, full, overflow;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // reference model: sorted, ties kept in arrival order
  logic [TIME_W-1:0] mt [DEPTH];
  logic [SIG_W-1:0]  ms [DEPTH];
  logic              mv [DEPTH];
  int                mcnt = 0;
  bit                movf = 1'b0;

  always #10 clk = ~clk;

  evq_top #(.DEPTH(DEPTH), .TIME_W(TIME_W), .SIG_W(SIG_W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_time(in_time), .in_sig(in_sig), .in_val(in_val),
    .pop_req(pop_req), .pop_valid(pop_valid), .pop_time(pop_time),
    .pop_sig(pop_sig), .pop_val(pop_val), .empty(empty), .full(full),
    .overflow(overflow)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_push(input logic [TIME_W-1:0] t, input logic [SIG_W-1:0] s, input logic v);
    int pos = 0;
    for (int i = 0; i < mcnt; i++) if (mt[i] <= t) pos = i + 1;
    for (int i = mcnt; i > pos; i--) begin
      mt[i] = mt[i-1]; ms[i] = ms[i-1]; mv[i] = mv[i-1];
    end
    mt[pos] = t; ms[pos] = s; mv[pos] = v;
    mcnt++;
  endtask

  task automatic model_pop();
    for (int i = 0; i < mcnt - 1; i++) begin
      mt[i] = mt[i+1]; ms[i] = ms[i+1]; mv[i] = mv[i+1];
    end
    mcnt--;
  endtask

  // one cycle: drive at negedge, check results at the following negedge
  task automatic step(input bit p, input int t, input int s, input bit v,
                      input bit q, input string tag);
    bit exp_rdy, acc, pok;
    logic [TIME_W-1:0] et;
    logic [SIG_W-1:0]  es;
    logic              ev;
    in_valid = p; in_time = TIME_W'(t); in_sig = SIG_W'(s); in_val = v;
    pop_req = q;
    #1;
    exp_rdy = (mcnt < DEPTH);
    chk(in_ready == exp_rdy, "R5", int'(in_ready), int'(exp_rdy));
    acc = p && exp_rdy;
    pok = q && (mcnt > 0);
    et = mt[0]; es = ms[0]; ev = mv[0];
    if (p && !exp_rdy) movf = 1'b1;
    if (pok) model_pop();
    if (acc) model_push(TIME_W'(t), SIG_W'(s), v);
    @(posedge clk);
    @(negedge clk);
    if (pok) begin
      chk(pop_valid == 1'b1, tag, int'(pop_valid), 1);
      chk(pop_time == et, tag, int'(pop_time), int'(et));
      chk({pop_sig, pop_val} == {es, ev}, tag, int'({pop_sig, pop_val}), int'({es, ev}));
    end else if (q) begin
      chk(pop_valid == 1'b0, "R7", int'(pop_valid), 0);
    end
    chk(empty == (mcnt == 0), "R4", int'(empty), int'(mcnt == 0));
    chk(full == (mcnt == DEPTH), "R5", int'(full), int'(mcnt == DEPTH));
    chk(overflow == movf, "R6", int'(overflow), int'(movf));
    in_valid = 1'b0; pop_req = 1'b0;
  endtask

  task automatic drain(input string tag);
    while (mcnt > 0) step(1'b0, 0, 0, 1'b0, 1'b1, tag);
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk(empty == 1'b1, "R1", int'(empty), 1);
    chk(full == 1'b0, "R1", int'(full), 0);
    chk(overflow == 1'b0, "R1", int'(overflow), 0);
    chk(pop_valid == 1'b0, "R1", int'(pop_valid), 0);
    chk(in_ready == 1'b1, "R1", int'(in_ready), 1);
    @(negedge clk);

    // R7: pop on empty, then confirm nothing appeared
    step(1'b0, 0, 0, 1'b0, 1'b1, "R7");
    step(1'b1, 33, 5, 1'b1, 1'b0, "R7");
    step(1'b0, 0, 0, 1'b0, 1'b1, "R7");
    step(1'b0, 0, 0, 1'b0, 1'b1, "R7");

    // R3: ties leave in arrival order
    step(1'b1, 25, 1, 1'b0, 1'b0, "R3");
    step(1'b1, 15, 2, 1'b1, 1'b0, "R3");
    step(1'b1, 25, 3, 1'b1, 1'b0, "R3");
    step(1'b1, 15, 4, 1'b0, 1'b0, "R3");
    step(1'b1, 25, 5, 1'b1, 1'b0, "R3");
    drain("R3");

    // R8: simultaneous add and pop returns the old head
    step(1'b1, 40, 1, 1'b1, 1'b0, "R8");
    step(1'b1, 10, 2, 1'b0, 1'b1, "R8");
    step(1'b1, 50, 3, 1'b1, 1'b1, "R8");
    step(1'b1, 5, 4, 1'b1, 1'b1, "R8");
    drain("R8");
    step(1'b1, 7, 6, 1'b0, 1'b1, "R8");
    drain("R8");

    // R9 extremes, then R5/R6 fill past capacity
    for (int i = 0; i < DEPTH; i++) begin
      int tv;
      tv = (i % 3 == 0) ? 16'hFFFF : (i % 3 == 1) ? 0 : (i * 997) & 16'hFFFF;
      step(1'b1, tv, i, i[0], 1'b0, "R9");
    end
    step(1'b1, 3, 9, 1'b1, 1'b0, "R6");
    step(1'b1, 2, 9, 1'b1, 1'b1, "R5");
    step(1'b0, 0, 0, 1'b0, 1'b0, "R6");
    drain("R9");

    // R2: mixed sweep, biased toward filling then draining
    r = 32'h1234_5678;
    for (int ph = 0; ph < 8; ph++) begin
      for (int k = 0; k < 120; k++) begin
        bit p, q;
        r = r * 32'd1103515245 + 32'd12345;
        p = (ph[0] == 1'b0) ? (r[7:6] != 2'b00) : (r[7:6] == 2'b00);
        q = (ph[0] == 1'b0) ? (r[9:8] == 2'b00) : (r[9:8] != 2'b00);
        step(p, int'(r[21:18]) + 10 * int'(r[23:22]), int'(r[27:24]), r[28], q, "R2");
      end
    end
    drain("R2");

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #3000000;
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule